// File: doc/BRIEF.md
# Four-Bank Interleaved Block Memory

This block is a memory made of four banks behind a data bus that is one word wide. Consecutive word addresses rotate across the banks, so word `a` sits in bank `a mod 4` at row `a / 4`. A cache-block read presents one aligned block address to every bank at once. All four banks run their access in the same cycles, and their four words then leave one per cycle on the shared bus. The cost of a block is therefore one address cycle, one access time and four transfer cycles. Four full accesses one after another would cost far more.

Single-word writes use the same address and access timing. They update only the bank that owns the word and then raise a one-cycle completion strobe. Bank storage is a register array with a fixed access latency set by a parameter (six cycles by default). The block accepts one request at a time and holds `req_ready` low until that request has finished.

Top module: `ilv_mem_top`

## Requirements
- R1: Word address `a` (8-bit word address) is stored in bank `a[1:0]` at row `a[7:2]`. A block read returns the word written to address `base + i` on the beat whose `rd_idx` equals `i`.
- R2: With the default access latency of 6, a block read accepted on clock edge E0 drives its first word after edge E7 and its last word after edge E10. `req_ready` is high again after edge E11, 11 cycles in total.
- R3: The four words of a block leave in ascending order on consecutive cycles. `rd_valid` is high for each of them, `rd_idx` runs 0, 1, 2, 3, and `rd_last` is high only with index 3.
- R4: `req_ready` is low from the edge that accepts a request until that request has completed. A request presented while `req_ready` is low is ignored and writes nothing.
- R5: For a block read, the two low address bits are ignored, so the block starts at the aligned address `addr & ~3`.
- R6: A write accepted on edge E0 raises `wr_done` for exactly the cycle after edge E7. `req_ready` returns after edge E8.
- R7: During and right after reset, `req_ready` is 1 and `rd_valid` and `wr_done` are 0. Reset does not clear the stored words.
- R8: A write changes only the addressed word. The other three words of the same block are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = single-word write, 0 = block read |
| req_addr | input | 8 | Word address (block reads ignore bits 1:0) |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block is idle and accepts a request |
| rd_valid | output | 1 | Read word present on `rd_data` |
| rd_data | output | 32 | Read word |
| rd_idx | output | 2 | Index of the word within its block |
| rd_last | output | 1 | Final word of the block |
| wr_done | output | 1 | Write completed (one-cycle pulse) |

## Verification
The assertions assume that `req_valid` is sampled only while `req_ready` is high. They also assume that each request keeps its address and data stable for the cycle in which it is accepted. The stimulus raises requests on the falling clock edge and holds them for exactly one accepting edge. It drives deliberate requests during busy periods only to show that they are refused. Reads target only words that were written earlier in the run, so no uninitialised storage ever reaches `rd_data`.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACCESS,
    ST_XFER,
    ST_DONE
  } ilv_state_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DW    = 32,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    q
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DW-1:0] mem [DEPTH];

  // storage array, written or read under an explicit clock enable
  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[row] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) begin
      q <= mem[row];
    end
  end
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int NBANKS  = 4,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int ACC_LAT = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [DW-1:0]             req_wdata,
  output logic                      req_ready,
  output logic                      acc_fire,
  output logic                      acc_write,
  output logic [AW-$clog2(NBANKS)-1:0] acc_row,
  output logic [$clog2(NBANKS)-1:0] acc_bank,
  output logic [DW-1:0]             acc_wdata,
  output logic                      xfer_valid,
  output logic [$clog2(NBANKS)-1:0] xfer_idx,
  output logic                      xfer_last,
  output logic                      wr_done
);
  localparam int BSEL_W = $clog2(NBANKS);
  localparam int CNT_W  = $clog2(ACC_LAT + 1);
  localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(ACC_LAT - 1);
  localparam logic [BSEL_W-1:0] IDX_END  = BSEL_W'(NBANKS - 1);

  ilv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BSEL_W-1:0] idx_q, idx_d;
  logic              capture;
  logic              wr_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          capture = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        state_d = ST_ACCESS;
        cnt_d   = CNT_LOAD;
      end
      ST_ACCESS: begin
        if (cnt_q == '0) begin
          state_d = wr_q ? ST_DONE : ST_XFER;
          idx_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_XFER: begin
        if (idx_q == IDX_END) begin
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  // request holding registers, clock enabled by acceptance
  always_ff @(posedge clk) begin
    if (capture) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign acc_fire   = (state_q == ST_ACCESS) && (cnt_q == '0);
  assign acc_write  = wr_q;
  assign acc_row    = addr_q[AW-1:BSEL_W];
  assign acc_bank   = addr_q[BSEL_W-1:0];
  assign acc_wdata  = wdata_q;
  assign xfer_valid = (state_q == ST_XFER);
  assign xfer_idx   = idx_q;
  assign xfer_last  = (state_q == ST_XFER) && (idx_q == IDX_END);
  assign wr_done    = (state_q == ST_DONE);

  // the access strobe is followed by data transfer or write completion
  assert_access_then_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (xfer_valid || wr_done));

  // no transfer or completion while the block advertises idle
  assert_ready_means_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!xfer_valid && !wr_done && !acc_fire));

  // the write completion lasts one cycle and frees the block
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (!wr_done && req_ready));

  // an accepted request drops ready on the next cycle
  assert_accept_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/ilv_serializer.sv
module ilv_serializer #(
  parameter int NBANKS = 4,
  parameter int DW     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xfer_valid,
  input  logic [$clog2(NBANKS)-1:0]    xfer_idx,
  input  logic                         xfer_last,
  input  logic [NBANKS-1:0][DW-1:0]    bank_q,
  output logic                         rd_valid,
  output logic [DW-1:0]                rd_data,
  output logic [$clog2(NBANKS)-1:0]    rd_idx,
  output logic                         rd_last
);
  assign rd_valid = xfer_valid;
  assign rd_idx   = xfer_idx;
  assign rd_last  = xfer_last;
  assign rd_data  = xfer_valid ? bank_q[xfer_idx] : '0;

  // a block always begins at word 0
  assert_first_word_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (rd_idx == '0));

  // consecutive beats carry ascending indices without gaps
  assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> (rd_valid && rd_idx == $past(rd_idx) + 1'b1));

  // the last beat ends the burst
  assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_last) |=> !rd_valid);
endmodule

// File: rtl/ilv_mem_top.sv
module ilv_mem_top #(
  parameter int NBANKS  = 4,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int ACC_LAT = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [DW-1:0]             req_wdata,
  output logic                      req_ready,
  output logic                      rd_valid,
  output logic [DW-1:0]             rd_data,
  output logic [$clog2(NBANKS)-1:0] rd_idx,
  output logic                      rd_last,
  output logic                      wr_done
);
  localparam int BSEL_W = $clog2(NBANKS);
  localparam int ROW_W  = AW - BSEL_W;

  logic                    acc_fire;
  logic                    acc_write;
  logic [ROW_W-1:0]        acc_row;
  logic [BSEL_W-1:0]       acc_bank;
  logic [DW-1:0]           acc_wdata;
  logic                    xfer_valid;
  logic [BSEL_W-1:0]       xfer_idx;
  logic                    xfer_last;
  logic [NBANKS-1:0][DW-1:0] bank_q;
  logic [NBANKS-1:0]       bank_en;
  logic [NBANKS-1:0]       bank_wr;

  ilv_ctrl #(
    .NBANKS(NBANKS), .DW(DW), .AW(AW), .ACC_LAT(ACC_LAT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready),
    .acc_fire(acc_fire), .acc_write(acc_write),
    .acc_row(acc_row), .acc_bank(acc_bank), .acc_wdata(acc_wdata),
    .xfer_valid(xfer_valid), .xfer_idx(xfer_idx), .xfer_last(xfer_last),
    .wr_done(wr_done)
  );

  // reads enable every bank; writes enable only the owning bank
  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    assign bank_en[g] = acc_fire && (!acc_write || acc_bank == BSEL_W'(g));
    assign bank_wr[g] = bank_en[g] && acc_write;

    ilv_bank #(.DW(DW), .ROW_W(ROW_W)) u_bank (
      .clk(clk), .en(bank_en[g]), .we(acc_write),
      .row(acc_row), .wdata(acc_wdata), .q(bank_q[g])
    );
  end

  ilv_serializer #(.NBANKS(NBANKS), .DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .xfer_valid(xfer_valid), .xfer_idx(xfer_idx), .xfer_last(xfer_last),
    .bank_q(bank_q),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_idx(rd_idx), .rd_last(rd_last)
  );

  // a write never touches more than one bank
  assert_single_bank_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));

  // a read wakes every bank together
  assert_parallel_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !acc_write) |-> (&bank_en));
endmodule

// File: tb/tb_ilv_mem_top.sv
module tb_ilv_mem_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NV = 12;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [1:0]    rd_idx;
  logic          rd_last;
  logic          wr_done;

  int checks;
  int errors;
  logic [DW-1:0] model [256];

  // {write op, address, data}
  localparam logic [AW+DW:0] VEC [NV] = '{
    {1'b1, 8'h10, 32'hA0A0_0010},
    {1'b1, 8'h11, 32'h1111_0011},
    {1'b1, 8'h12, 32'h2222_0012},
    {1'b1, 8'h13, 32'h3333_0013},
    {1'b1, 8'h14, 32'h4444_0014},
    {1'b1, 8'h15, 32'h5555_0015},
    {1'b1, 8'h16, 32'h6666_0016},
    {1'b1, 8'h17, 32'h7777_0017},
    {1'b0, 8'h10, 32'h0},
    {1'b0, 8'h17, 32'h0},
    {1'b1, 8'h15, 32'h5A5A_A5A5},
    {1'b0, 8'h14, 32'h0}
  };

  ilv_mem_top dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_idx(rd_idx),
    .rd_last(rd_last), .wr_done(wr_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    model[a] = d;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(wr_done == (k == 7), "R6 wr_done", 32'(wr_done), 32'(k == 7));
      chk(req_ready == (k == 8), "R4 ready during write", 32'(req_ready), 32'(k == 8));
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic intrude);
    logic [AW-1:0] base;
    base = {a[AW-1:2], 2'b00};
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 11; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (intrude && k == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = base + 8'd1;
        req_wdata = 32'hDEAD_BEEF;
      end
      if (intrude && k == 5) req_valid = 1'b0;
      chk(rd_valid == (k >= 7 && k <= 10), "R2 rd_valid timing",
          32'(rd_valid), 32'(k >= 7 && k <= 10));
      chk(req_ready == (k == 11), "R4 ready during read", 32'(req_ready), 32'(k == 11));
      if (k >= 7 && k <= 10) begin
        chk(rd_idx == 2'(k - 7), "R3 word index", 32'(rd_idx), 32'(k - 7));
        chk(rd_last == (k == 10), "R3 last flag", 32'(rd_last), 32'(k == 10));
        chk(rd_data == model[base + 8'(k - 7)], "R1/R5 read word",
            rd_data, model[base + 8'(k - 7)]);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(req_ready == 1'b1, "R7 ready in reset", 32'(req_ready), 32'h1);
    chk(rd_valid == 1'b0, "R7 rd_valid in reset", 32'(rd_valid), 32'h0);
    chk(wr_done == 1'b0, "R7 wr_done in reset", 32'(wr_done), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: writes update the model, reads compare four words
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][AW+DW]) do_write(VEC[v][AW+DW-1:DW], VEC[v][DW-1:0]);
      else               do_read(VEC[v][AW+DW-1:DW], 1'b0);
    end

    // R1: one word per bank in a fresh block, read starting at a misaligned address (R5)
    do_write(8'h40, 32'hB000_0000);
    do_write(8'h41, 32'hB111_1111);
    do_write(8'h42, 32'hB222_2222);
    do_write(8'h43, 32'hB333_3333);
    do_read(8'h42, 1'b0);

    // R4: a write offered while busy is ignored; the stored word stays intact
    do_read(8'h40, 1'b1);
    do_read(8'h41, 1'b0);

    // R8: write one word and verify its three neighbours in the block
    do_write(8'h42, 32'hC0FF_EE00);
    do_read(8'h40, 1'b0);

    // R7: reset in the middle of a block read, then storage must survive
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready after mid reset", 32'(req_ready), 32'h1);
    chk(rd_valid == 1'b0, "R7 rd_valid after mid reset", 32'(rd_valid), 32'h0);
    chk(wr_done == 1'b0, "R7 wr_done after mid reset", 32'(wr_done), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(8'h14, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule